// File: doc/BRIEF.md
# Hub Attach and Reset Sequencer

This block brings a USB hub device from power-up to an attached state on the upstream link. It takes a chip reset request and passes it through a two-flop synchroniser. The synchronised reset then acts as a synchronous reset in the block's own clock domain. After reset the block runs a fixed-length configuration stage. On entry to that stage it captures the two reference-select pins and decodes them into a reference frequency code. It then waits for permission to connect. When permission is given it raises the pull-up connect request.

Permission to connect depends on whether an external configuration master is present. With no master, the connect-enable input alone is enough. With a master, the block also needs a software attach bit that the master sets once it has finished configuring the device. The attach bit keeps its value until the next chip reset.

While attached, the enumeration logic loads the device address and sets the configured flag through one-cycle strobes. An upstream bus reset clears the address, the configured flag and the suspended flag. It never drives the downstream port resets, which follow the chip reset only.

Top module: `hub_bringup_seq`

## Requirements
- R1: The chip reset request passes through a two-flop synchroniser. While the synchronised reset is high, the next clock edge puts the sequencer in the reset state (state_o = 0). That edge also clears the device address, the configured flag, the suspended flag and the software attach bit.
- R2: While state_o = 0, phy_en_o is low and every bit of ds_port_rst_o is high. While the synchronised reset is high, both HSIC outputs are low one cycle later. Outside reset, each HSIC output follows its link input with one cycle of delay.
- R3: refsel_i is captured only on the edge that moves the state from reset (0) to configuration (1). Changes to refsel_i at any later time leave refsel_lat_o unchanged.
- R4: freq_code_o gives the reference frequency in units of 100 kHz for the captured selection: 00 gives 384, 01 gives 260, 10 gives 192 and 11 gives 120.
- R5: When no configuration master is present (cfg_master_i = 0), the wait state (2) moves to the attached state (3) on the first edge at which conn_en_i is high. pullup_o is high exactly while state_o = 3.
- R6: When cfg_master_i = 1, the wait state stays put until the software attach bit has been set by a pulse on attach_set_i on an earlier edge. After that, it moves to attached on the first edge at which conn_en_i is also high.
- R7: A bus_rst_i pulse clears dev_addr_o, configured_o and suspended_o on that edge. It takes priority over any address, configure or suspend strobe in the same cycle.
- R8: A bus reset leaves ds_port_rst_o at all zeros and does not change state_o.
- R9: If conn_en_i is low at an edge while attached, the state returns to wait (2) and the address, configured and suspended flags are cleared. The attach bit is kept, so a later rise of conn_en_i reconnects with no new attach_set_i pulse.
- R10: The configuration state lasts exactly CFG_CYCLES cycles and is followed by the wait state. The state codes are 0 reset, 1 configuration, 2 wait and 3 attached.
- R11: set_addr_i loads addr_i into dev_addr_o, and set_cfg_i sets configured_o. Each takes effect only on an edge where the state is attached and conn_en_i is high; in any other state the outputs stay 0.
- R12: susp_set_i sets suspended_o under the same attached-and-connected condition as R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| chip_rst_req_i | input | 1 | Chip reset request, active high, asynchronous to clk_i |
| bus_rst_i | input | 1 | One-cycle upstream bus reset event |
| refsel_i | input | 2 | Reference clock select pins |
| conn_en_i | input | 1 | Connect enable, equivalent to upstream VBUS |
| cfg_master_i | input | 1 | An external configuration master is present |
| attach_set_i | input | 1 | Write strobe from the master that sets the software attach bit |
| link_stb_i | input | 1 | HSIC strobe from the link layer |
| link_dat_i | input | 1 | HSIC data from the link layer |
| set_addr_i | input | 1 | Set-address strobe from enumeration logic |
| addr_i | input | ADDR_W | Address value loaded by set_addr_i |
| set_cfg_i | input | 1 | Set-configuration strobe from enumeration logic |
| susp_set_i | input | 1 | Upstream suspend detected strobe |
| state_o | output | 2 | Sequencer state code |
| pullup_o | output | 1 | Pull-up connect request |
| phy_en_o | output | 1 | PHY enable; low lets the differential pairs float |
| hsic_stb_o | output | 1 | HSIC strobe output |
| hsic_dat_o | output | 1 | HSIC data output |
| refsel_lat_o | output | 2 | Captured reference selection |
| freq_code_o | output | 9 | Reference frequency in 100 kHz units |
| dev_addr_o | output | ADDR_W | Device address |
| configured_o | output | 1 | Device configured flag |
| suspended_o | output | 1 | Device suspended flag |
| ds_port_rst_o | output | N_DS_PORTS | Reset to each downstream port |

## Verification
The bench changes the reference pins right after the configuration stage starts. A design that sampled them continuously would then report the wrong frequency code. With a master present, it holds the connect input high and never sets the attach bit, so a design that ignored the master flag would raise the pull-up too early. It drops and restores the connect input with no new attach write. A design that cleared the attach bit on disconnect would then stay in wait. Bus resets are fired together with address and configure strobes, and alongside random traffic the downstream resets are checked to stay low, which catches wrong priority and a reset that leaks to the downstream ports.

// File: rtl/hub_bringup_pkg.sv
package hub_bringup_pkg;

   typedef enum logic [1:0] {
      ST_RESET    = 2'd0,
      ST_CONFIG   = 2'd1,
      ST_WAIT     = 2'd2,
      ST_ATTACHED = 2'd3
   } hub_state_e;

   localparam int FREQ_W   = 9;
   localparam int REFSEL_W = 2;

   // Reference frequency in 100 kHz units for each select code.
   function automatic logic [FREQ_W-1:0] refsel_to_freq(input logic [REFSEL_W-1:0] sel);
      logic [FREQ_W-1:0] f;
      case (sel)
         2'b00:   f = FREQ_W'(384);
         2'b01:   f = FREQ_W'(260);
         2'b10:   f = FREQ_W'(192);
         default: f = FREQ_W'(120);
      endcase
      return f;
   endfunction

endpackage

// File: rtl/hub_rst_sync.sv
module hub_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic req_i,
   output logic rst_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hub_rst_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i) begin
      chain_q <= {chain_q[STAGES-2:0], req_i};
   end

   assign rst_o = chain_q[STAGES-1];
endmodule

// File: rtl/hub_state_ctl.sv
module hub_state_ctl
   import hub_bringup_pkg::*;
#(
   parameter int CFG_CYCLES = 4
) (
   input  logic       clk_i,
   input  logic       rst_i,
   input  logic       conn_en_i,
   input  logic       cfg_master_i,
   input  logic       attach_set_i,
   output hub_state_e state_o,
   output logic       attach_q_o,
   output logic       stay_att_o,
   output logic       latch_now_o
);
   localparam int CNT_W = $clog2(CFG_CYCLES + 1);

   generate
      if (CFG_CYCLES < 1) begin : g_bad_cfg
         $error("hub_state_ctl: CFG_CYCLES must be at least 1");
      end
   endgenerate

   hub_state_e        state_q, state_d;
   logic [CNT_W-1:0]  cnt_q;
   logic              attach_q;
   logic              may_attach;

   assign may_attach = conn_en_i && (!cfg_master_i || attach_q);

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_RESET:    state_d = ST_CONFIG;
         ST_CONFIG:   if (cnt_q == CNT_W'(CFG_CYCLES - 1)) state_d = ST_WAIT;
         ST_WAIT:     if (may_attach) state_d = ST_ATTACHED;
         ST_ATTACHED: if (!conn_en_i) state_d = ST_WAIT;
         default:     state_d = ST_RESET;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q  <= ST_RESET;
         cnt_q    <= '0;
         attach_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_CONFIG) cnt_q <= cnt_q + CNT_W'(1);
         else                      cnt_q <= '0;
         if (attach_set_i) attach_q <= 1'b1;
      end
   end

   assign state_o     = state_q;
   assign attach_q_o  = attach_q;
   assign stay_att_o  = (state_q == ST_ATTACHED) && conn_en_i;
   assign latch_now_o = (state_q == ST_RESET) && !rst_i;
endmodule

// File: rtl/hub_clksel.sv
module hub_clksel
   import hub_bringup_pkg::*;
#(
   parameter bit REG_OUT = 1'b0
) (
   input  logic                clk_i,
   input  logic                rst_i,
   input  logic                latch_now_i,
   input  logic [REFSEL_W-1:0] refsel_i,
   output logic [REFSEL_W-1:0] refsel_q_o,
   output logic [FREQ_W-1:0]   freq_o
);
   logic [REFSEL_W-1:0] sel_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)            sel_q <= '0;
      else if (latch_now_i) sel_q <= refsel_i;
   end

   assign refsel_q_o = sel_q;

   generate
      if (REG_OUT) begin : g_reg_freq
         logic [FREQ_W-1:0] freq_q;
         always_ff @(posedge clk_i) begin
            if (rst_i) freq_q <= refsel_to_freq('0);
            else       freq_q <= refsel_to_freq(sel_q);
         end
         assign freq_o = freq_q;
      end else begin : g_comb_freq
         assign freq_o = refsel_to_freq(sel_q);
      end
   endgenerate
endmodule

// File: rtl/hub_dev_regs.sv
module hub_dev_regs #(
   parameter int ADDR_W = 7
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              stay_att_i,
   input  logic              bus_rst_i,
   input  logic              set_addr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              set_cfg_i,
   input  logic              susp_set_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              cfg_o,
   output logic              susp_o
);
   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("hub_dev_regs: ADDR_W must be at least 1");
      end
   endgenerate

   logic              clear;
   logic [ADDR_W-1:0] addr_q;
   logic              cfg_q, susp_q;

   assign clear = rst_i || !stay_att_i || bus_rst_i;

   always_ff @(posedge clk_i) begin
      if (clear) begin
         addr_q <= '0;
         cfg_q  <= 1'b0;
         susp_q <= 1'b0;
      end else begin
         if (set_addr_i) addr_q <= addr_i;
         if (set_cfg_i)  cfg_q  <= 1'b1;
         if (susp_set_i) susp_q <= 1'b1;
      end
   end

   assign addr_o = addr_q;
   assign cfg_o  = cfg_q;
   assign susp_o = susp_q;
endmodule

// File: rtl/hub_bringup_seq.sv
module hub_bringup_seq
   import hub_bringup_pkg::*;
#(
   parameter int ADDR_W     = 7,
   parameter int N_DS_PORTS = 3,
   parameter int CFG_CYCLES = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit REG_FREQ   = 1'b0
) (
   input  logic              clk_i,
   input  logic              chip_rst_req_i,
   input  logic              bus_rst_i,
   input  logic [1:0]        refsel_i,
   input  logic              conn_en_i,
   input  logic              cfg_master_i,
   input  logic              attach_set_i,
   input  logic              link_stb_i,
   input  logic              link_dat_i,
   input  logic              set_addr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              set_cfg_i,
   input  logic              susp_set_i,
   output logic [1:0]        state_o,
   output logic              pullup_o,
   output logic              phy_en_o,
   output logic              hsic_stb_o,
   output logic              hsic_dat_o,
   output logic [1:0]        refsel_lat_o,
   output logic [8:0]        freq_code_o,
   output logic [ADDR_W-1:0] dev_addr_o,
   output logic              configured_o,
   output logic              suspended_o,
   output logic [N_DS_PORTS-1:0] ds_port_rst_o
);
   generate
      if (N_DS_PORTS < 1) begin : g_bad_ports
         $error("hub_bringup_seq: N_DS_PORTS must be at least 1");
      end
      if (FREQ_W != 9) begin : g_bad_freq
         $error("hub_bringup_seq: frequency code width mismatch");
      end
   endgenerate

   logic       rst_s;
   hub_state_e state;
   logic       attach_q;
   logic       stay_att;
   logic       latch_now;

   hub_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .req_i (chip_rst_req_i),
      .rst_o (rst_s)
   );

   hub_state_ctl #(.CFG_CYCLES(CFG_CYCLES)) u_ctl (
      .clk_i        (clk_i),
      .rst_i        (rst_s),
      .conn_en_i    (conn_en_i),
      .cfg_master_i (cfg_master_i),
      .attach_set_i (attach_set_i),
      .state_o      (state),
      .attach_q_o   (attach_q),
      .stay_att_o   (stay_att),
      .latch_now_o  (latch_now)
   );

   hub_clksel #(.REG_OUT(REG_FREQ)) u_clk (
      .clk_i       (clk_i),
      .rst_i       (rst_s),
      .latch_now_i (latch_now),
      .refsel_i    (refsel_i),
      .refsel_q_o  (refsel_lat_o),
      .freq_o      (freq_code_o)
   );

   hub_dev_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk_i      (clk_i),
      .rst_i      (rst_s),
      .stay_att_i (stay_att),
      .bus_rst_i  (bus_rst_i),
      .set_addr_i (set_addr_i),
      .addr_i     (addr_i),
      .set_cfg_i  (set_cfg_i),
      .susp_set_i (susp_set_i),
      .addr_o     (dev_addr_o),
      .cfg_o      (configured_o),
      .susp_o     (suspended_o)
   );

   // HSIC lines are held low through chip reset.
   logic stb_q, dat_q;
   always_ff @(posedge clk_i) begin
      if (rst_s) begin
         stb_q <= 1'b0;
         dat_q <= 1'b0;
      end else begin
         stb_q <= link_stb_i;
         dat_q <= link_dat_i;
      end
   end

   assign hsic_stb_o = stb_q;
   assign hsic_dat_o = dat_q;
   assign state_o    = state;
   assign pullup_o   = (state == ST_ATTACHED);
   assign phy_en_o   = (state != ST_RESET);

   // Downstream resets follow the chip reset only; bus reset never reaches them.
   generate
      for (genvar g = 0; g < N_DS_PORTS; g++) begin : g_ds_rst
         assign ds_port_rst_o[g] = (state == ST_RESET);
      end
   endgenerate
endmodule

// File: rtl/hub_bringup_seq_chk.sv
module hub_bringup_seq_chk #(
   parameter int ADDR_W  = 7,
   parameter int N_PORTS = 3
) (
   input logic              clk_i,
   input logic              rst_s,
   input logic [1:0]        state_o,
   input logic              conn_en_i,
   input logic              cfg_master_i,
   input logic              attach_q,
   input logic              pullup_o,
   input logic [1:0]        refsel_lat_o,
   input logic              bus_rst_i,
   input logic [ADDR_W-1:0] dev_addr_o,
   input logic              configured_o,
   input logic              suspended_o,
   input logic [N_PORTS-1:0] ds_port_rst_o,
   input logic              phy_en_o,
   input logic              hsic_stb_o,
   input logic              hsic_dat_o
);
   logic armed;
   always_ff @(posedge clk_i) begin
      if (rst_s) armed <= 1'b1;
   end

   p_reset_outputs_r2: assert property (@(posedge clk_i) disable iff (!armed)
      rst_s |=> (!phy_en_o && !hsic_stb_o && !hsic_dat_o && (&ds_port_rst_o)));

   p_refsel_hold_r3: assert property (@(posedge clk_i) disable iff (rst_s || !armed)
      (state_o != 2'd0 && $past(state_o) != 2'd0) |-> $stable(refsel_lat_o));

   p_no_conn_no_pullup_r5: assert property (@(posedge clk_i) disable iff (rst_s || !armed)
      (state_o == 2'd2 && !conn_en_i) |=> !pullup_o);

   p_master_gate_r6: assert property (@(posedge clk_i) disable iff (rst_s || !armed)
      (state_o == 2'd2 && cfg_master_i && !attach_q) |=> (state_o != 2'd3));

   p_busrst_clears_r7: assert property (@(posedge clk_i) disable iff (rst_s || !armed)
      bus_rst_i |=> (dev_addr_o == '0 && !configured_o && !suspended_o));

   p_busrst_no_ds_r8: assert property (@(posedge clk_i) disable iff (rst_s || !armed)
      (bus_rst_i && state_o == 2'd3) |=> (ds_port_rst_o == '0));

   p_cfg_only_att_r11: assert property (@(posedge clk_i) disable iff (rst_s || !armed)
      $rose(configured_o) |-> ($past(state_o) == 2'd3));
endmodule

bind hub_bringup_seq hub_bringup_seq_chk #(.ADDR_W(ADDR_W), .N_PORTS(N_DS_PORTS)) u_chk (
   .clk_i        (clk_i),
   .rst_s        (rst_s),
   .state_o      (state_o),
   .conn_en_i    (conn_en_i),
   .cfg_master_i (cfg_master_i),
   .attach_q     (attach_q),
   .pullup_o     (pullup_o),
   .refsel_lat_o (refsel_lat_o),
   .bus_rst_i    (bus_rst_i),
   .dev_addr_o   (dev_addr_o),
   .configured_o (configured_o),
   .suspended_o  (suspended_o),
   .ds_port_rst_o(ds_port_rst_o),
   .phy_en_o     (phy_en_o),
   .hsic_stb_o   (hsic_stb_o),
   .hsic_dat_o   (hsic_dat_o)
);

// File: tb/hub_bringup_seq_tb.sv
module hub_bringup_seq_tb_top;
   localparam int ADDR_W = 7;
   localparam int NP     = 3;
   localparam int CFGC   = 4;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic chip_rst_req = 1'b1, bus_rst = 1'b0, conn_en = 1'b0, cfg_master = 1'b0;
   logic attach_set = 1'b0, link_stb = 1'b1, link_dat = 1'b1;
   logic set_addr = 1'b0, set_cfg = 1'b0, susp_set = 1'b0;
   logic [1:0] refsel = 2'b00;
   logic [ADDR_W-1:0] addr_in = '0;

   logic [1:0] state_o, refsel_lat_o;
   logic pullup_o, phy_en_o, hsic_stb_o, hsic_dat_o, configured_o, suspended_o;
   logic [8:0] freq_code_o;
   logic [ADDR_W-1:0] dev_addr_o;
   logic [NP-1:0] ds_port_rst_o;

   hub_bringup_seq #(.ADDR_W(ADDR_W), .N_DS_PORTS(NP), .CFG_CYCLES(CFGC)) dut_i (
      .clk_i(clk), .chip_rst_req_i(chip_rst_req), .bus_rst_i(bus_rst), .refsel_i(refsel),
      .conn_en_i(conn_en), .cfg_master_i(cfg_master), .attach_set_i(attach_set),
      .link_stb_i(link_stb), .link_dat_i(link_dat), .set_addr_i(set_addr), .addr_i(addr_in),
      .set_cfg_i(set_cfg), .susp_set_i(susp_set), .state_o(state_o), .pullup_o(pullup_o),
      .phy_en_o(phy_en_o), .hsic_stb_o(hsic_stb_o), .hsic_dat_o(hsic_dat_o),
      .refsel_lat_o(refsel_lat_o), .freq_code_o(freq_code_o), .dev_addr_o(dev_addr_o),
      .configured_o(configured_o), .suspended_o(suspended_o), .ds_port_rst_o(ds_port_rst_o));

   int n_cmp = 0, n_bad = 0;
   int m_st, m_addr;
   bit m_att, m_cfg, m_susp;

   function automatic int exp_freq(input logic [1:0] s);
      case (s)
         2'b00: return 384;
         2'b01: return 260;
         2'b10: return 192;
         default: return 120;
      endcase
   endfunction

   function automatic int next_st(input int st, input bit conn, input bit master, input bit att);
      if (st == 2 && conn && (!master || att)) return 3;
      if (st == 3 && !conn) return 2;
      return st;
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic cmp_all(input string st_req);
      chk(st_req, "state", state_o, m_st);
      chk("R5", "pullup", pullup_o, (m_st == 3));
      chk("R11", "address", dev_addr_o, m_addr);
      chk("R11", "configured", configured_o, m_cfg);
      chk("R12", "suspended", suspended_o, m_susp);
      chk("R8", "downstream reset", ds_port_rst_o, 0);
      chk("R2", "phy enable", phy_en_o, 1);
   endtask

   task automatic model_update();
      bit stay;
      stay = (m_st == 3) && conn_en;
      if (!stay || bus_rst) begin
         m_addr = 0; m_cfg = 0; m_susp = 0;
      end else begin
         if (set_addr) m_addr = addr_in;
         if (set_cfg)  m_cfg = 1;
         if (susp_set) m_susp = 1;
      end
      m_st = next_st(m_st, conn_en, cfg_master, m_att);
      if (attach_set) m_att = 1;
   endtask

   task automatic step(input string st_req);
      @(posedge clk);
      #1;
      model_update();
      @(negedge clk);
      cmp_all(st_req);
      bus_rst = 0; set_addr = 0; set_cfg = 0; susp_set = 0; attach_set = 0;
   endtask

   task automatic chip_reset(input logic [1:0] sel, input bit master);
      int cnt;
      @(negedge clk);
      chip_rst_req = 1; conn_en = 0; cfg_master = master; refsel = sel;
      link_stb = 1; link_dat = 1;
      repeat (8) @(negedge clk);
      chk("R1", "state in reset", state_o, 0);
      chk("R1", "address in reset", dev_addr_o, 0);
      chk("R1", "configured in reset", configured_o, 0);
      chk("R2", "phy enable in reset", phy_en_o, 0);
      chk("R2", "hsic in reset", {hsic_stb_o, hsic_dat_o}, 0);
      chk("R2", "downstream reset", ds_port_rst_o, (1 << NP) - 1);
      chk("R5", "pullup in reset", pullup_o, 0);
      chip_rst_req = 0;
      cnt = 0;
      while (state_o != 2'd1 && cnt < 10) begin
         @(negedge clk);
         cnt++;
      end
      refsel = ~sel;
      cnt = 0;
      while (state_o == 2'd1 && cnt < 50) begin
         cnt++;
         @(negedge clk);
      end
      chk("R10", "config length", cnt, CFGC);
      chk("R10", "state after config", state_o, 2);
      chk("R3", "latched refsel", refsel_lat_o, sel);
      chk("R4", "frequency code", freq_code_o, exp_freq(sel));
      chk("R2", "hsic follows link", {hsic_stb_o, hsic_dat_o}, 3);
      m_st = 2; m_att = 0; m_addr = 0; m_cfg = 0; m_susp = 0;
   endtask

   task automatic random_run(input int cycles);
      for (int i = 0; i < cycles; i++) begin
         if ($urandom % 12 == 0) conn_en = ~conn_en;
         bus_rst    = ($urandom % 20 == 0);
         set_addr   = ($urandom % 8 == 0);
         addr_in    = ADDR_W'($urandom);
         set_cfg    = ($urandom % 8 == 0);
         susp_set   = ($urandom % 16 == 0);
         attach_set = ($urandom % 64 == 0);
         step("R9");
      end
   endtask

   initial begin
      int sd;
      sd = $urandom(32'h5eed_2014);
      // Reset and no-master attach
      chip_reset(2'b00, 1'b0);
      set_cfg = 1; step("R11");
      conn_en = 1; step("R5");
      chk("R5", "attached without master", state_o, 3);
      set_addr = 1; addr_in = 7'd5; step("R11");
      chk("R11", "address loaded", dev_addr_o, 5);
      set_cfg = 1; susp_set = 1; step("R12");
      chk("R12", "suspended set", suspended_o, 1);
      bus_rst = 1; set_addr = 1; addr_in = 7'd9; set_cfg = 1; step("R8");
      chk("R7", "address after bus reset", dev_addr_o, 0);
      chk("R7", "suspend cleared by bus reset", suspended_o, 0);
      chk("R8", "state kept on bus reset", state_o, 3);
      // Master present: attach bit gating and retention
      chip_reset(2'b01, 1'b1);
      conn_en = 1;
      for (int i = 0; i < 20; i++) step("R6");
      chk("R6", "held without attach bit", pullup_o, 0);
      attach_set = 1; step("R6");
      step("R6");
      chk("R6", "attached after attach bit", state_o, 3);
      conn_en = 0; step("R9");
      chk("R9", "back to wait on disconnect", state_o, 2);
      conn_en = 1; step("R9");
      chk("R9", "reconnect keeps attach bit", state_o, 3);
      random_run(1500);
      chip_reset(2'b10, 1'b0);
      random_run(1500);
      chip_reset(2'b11, 1'b1);
      random_run(2000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd == 150000) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d cycles", wd, 0);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule